// File: doc/BRIEF.md
# Quad 8-bit DAC Serial Register Interface

This block holds the digital register path of a four-channel, 8-bit digital-to-analog converter. A host shifts a 16-bit word in over a three-wire serial link: a serial clock, an active-low frame select and a data line. Each channel is double-buffered. A completed word lands in the staging register of the channel it addresses. The converter-facing register of that channel changes only when the active-low update strobe permits it. An active-low wipe input zeroes both register banks. A shutdown input is passed to a flag output and leaves the stored codes alone.

All serial and strobe inputs are treated as asynchronous. Each one passes through a two-flop synchroniser into the system clock domain, and the serial clock and frame select are then edge-detected there. A three-state front-end machine sequences the transfer:

- **ST_IDLE**: no frame is open.
- **ST_SHIFT**: the frame select is low.
- **ST_COMMIT**: a one-cycle write pulse.

The transitions between these states are:

- **IDLE→SHIFT**: the synchronised frame select is seen low.
- **SHIFT→COMMIT**: the frame select is seen high again.
- **COMMIT→IDLE**: always, after one cycle.

Serial bits are shifted in whenever the synchronised frame select is low, in ST_IDLE or ST_SHIFT.

Top module: `quad_dac_regif`

## Requirements
- R1: After system reset every staging and converter register reads zero, the shutdown flag is 0 and the serial shift register is zero.
- R2: While the frame select is low, each rising serial clock edge shifts the data line into the shift register, most significant bit first. In the 16-bit word, bits [15:14] select the channel (00 = A, 01 = B, 10 = C, 11 = D), bits [13:8] are ignored and bits [7:0] carry the code. The `dac_o` bits [7:0] carry channel A, [15:8] channel B, [23:16] channel C and [31:24] channel D.
- R3: A rising frame select writes only the addressed channel's staging register. The other three keep their values.
- R4: While the frame select is high, serial clock edges do not change the shift register.
- R5: While the update strobe is high, the converter registers hold their values. A low pulse on the strobe copies all four staging registers into them together.
- R6: While the update strobe is held low, each converter register follows its staging register, so a completed word reaches the output without a further strobe.
- R7: A low wipe input zeroes all staging and converter registers and leaves the serial shift register as it was.
- R8: The wipe takes priority over the update strobe and over serial writes. While it is low, all registers stay zero.
- R9: The shutdown flag follows the shutdown input, and raising it leaves all converter register values unchanged.
- R10: A frame with more or fewer than 16 serial clocks is decoded from the last 16 bits shifted in. This can include bits left over from the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Active-low frame select, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| ldac_n_i | input | 1 | Active-low update strobe, level-sensitive |
| clr_n_i | input | 1 | Active-low wipe of staging and converter registers |
| shdn_i | input | 1 | Shutdown request |
| dac_o | output | CH_NUM*DATA_W | Converter register values, channel A in the lowest byte |
| shdn_o | output | 1 | Output-disable flag |

## Verification
Each input is due at a fixed number of system cycles after it changes:

- **Frame select rise**: reaches a staging register four cycles later (two synchroniser stages, the edge register and the commit cycle).
- **Update strobe**: copies into the converter registers three cycles after it falls.
- **Wipe**: zeroes the registers three cycles after it falls.
- **Shutdown flag**: follows the input after two cycles.

The bench drives every serial half-period and strobe for at least four system cycles. Its monitor compares the outputs eight cycles after each expected item is queued, so every result has settled before it is sampled and no new stimulus has started.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } fe_state_t;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int unsigned  W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/qdac_serial_fe.sv
module qdac_serial_fe
    import qdac_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    fe_state_t         state_q, state_d;
    logic              sclk_q;
    logic [WORD_W-1:0] shreg_q;
    logic              shift_en;

    assign shift_en = sclk_s & ~sclk_q & ~csn_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!csn_s) state_d = ST_SHIFT;
            ST_SHIFT:  if (csn_s)  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   wr_en = 1'b0;
            ST_SHIFT:  wr_en = 1'b0;
            ST_COMMIT: wr_en = 1'b1;
            default:   wr_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            shreg_q <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (shift_en) shreg_q <= {shreg_q[WORD_W-2:0], sdi_s};
        end
    end

    assign wr_addr = shreg_q[WORD_W-1 -: ADDR_W];
    assign wr_data = shreg_q[DATA_W-1:0];

    // frame select high freezes the shift register
    assert_cs_high_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> $stable(shreg_q))
        else $error("shift register moved while frame select high");

    // one write pulse per frame
    assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en)
        else $error("write pulse longer than one cycle");

    assert_commit_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(csn_s))
        else $error("commit without frame select high");

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank #(
    parameter int unsigned CH_NUM = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_s,
    input  logic                     ldac_s,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [CH_NUM*DATA_W-1:0] dac_flat
);

    localparam int unsigned FLAT_W = CH_NUM * DATA_W;

    logic [FLAT_W-1:0] inp_flat;

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        logic [DATA_W-1:0] inp_q;
        logic [DATA_W-1:0] dac_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                inp_q <= '0;
                dac_q <= '0;
            end else if (!clr_s) begin
                inp_q <= '0;
                dac_q <= '0;
            end else begin
                if (wr_en && (wr_addr == ADDR_W'(c))) inp_q <= wr_data;
                if (!ldac_s) dac_q <= inp_q;
            end
        end

        assign inp_flat[c*DATA_W +: DATA_W] = inp_q;
        assign dac_flat[c*DATA_W +: DATA_W] = dac_q;
    end

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (dac_flat == '0) && (inp_flat == '0))
        else $error("wipe did not zero registers");

    assert_dac_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && ldac_s) |=> $stable(dac_flat))
        else $error("converter register moved with strobe high");

    assert_dac_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && !ldac_s) |=> (dac_flat == $past(inp_flat)))
        else $error("converter register did not follow staging");

    assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && !wr_en) |=> $stable(inp_flat))
        else $error("staging register changed without write");

endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif #(
    parameter int unsigned CH_NUM = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_i,
    input  logic                     csn_i,
    input  logic                     sdi_i,
    input  logic                     ldac_n_i,
    input  logic                     clr_n_i,
    input  logic                     shdn_i,
    output logic [CH_NUM*DATA_W-1:0] dac_o,
    output logic                     shdn_o
);

    localparam int unsigned ADDR_W = (CH_NUM > 1) ? $clog2(CH_NUM) : 1;
    localparam int unsigned SYNC_W = 6;
    // order: sclk, csn, sdi, ldac_n, clr_n, shdn
    localparam logic [SYNC_W-1:0] SYNC_RST = 6'b010110;

    logic [SYNC_W-1:0] raw_in, syn_out;
    logic              sclk_s, csn_s, sdi_s, ldac_s, clr_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    assign raw_in = {sclk_i, csn_i, sdi_i, ldac_n_i, clr_n_i, shdn_i};
    assign {sclk_s, csn_s, sdi_s, ldac_s, clr_s, shdn_o} = syn_out;

    qdac_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_out)
    );

    qdac_serial_fe #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fe (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .csn_s   (csn_s),
        .sdi_s   (sdi_s),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    qdac_regbank #(.CH_NUM(CH_NUM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_s    (clr_s),
        .ldac_s   (ldac_s),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dac_flat (dac_o)
    );

    assert_shdn_keeps_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(shdn_o) && clr_s && ldac_s) |=> $stable(dac_o))
        else $error("shutdown altered converter codes");

endmodule

// File: tb/quad_dac_regif_bench.sv
`timescale 1ns/1ps
module quad_dac_regif_bench;

    typedef struct {
        string       tag;
        logic [31:0] dac;
        logic        shdn;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
    logic        ldac_n = 1'b1, clr_n = 1'b1, shdn = 1'b0;
    logic [31:0] dac_o;
    logic        shdn_o;

    int   tests = 0, fails = 0;
    bit   done = 1'b0;
    exp_t q[$];

    logic [7:0]  m_inp [4];
    logic [7:0]  m_dac [4];
    logic [15:0] m_sh = '0;
    bit          m_ldac_low = 1'b0;
    bit          m_clr_low  = 1'b0;

    always #10 clk = ~clk;

    quad_dac_regif u_quad_dac_regif (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
        .ldac_n_i(ldac_n), .clr_n_i(clr_n), .shdn_i(shdn),
        .dac_o(dac_o), .shdn_o(shdn_o)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_settle();
        if (m_clr_low) begin
            for (int c = 0; c < 4; c++) begin m_inp[c] = '0; m_dac[c] = '0; end
        end else if (m_ldac_low) begin
            for (int c = 0; c < 4; c++) m_dac[c] = m_inp[c];
        end
    endtask

    task automatic send_bit(logic b);
        sdi = b; tick(4);
        sclk = 1'b1;
        if (!csn) m_sh = {m_sh[14:0], b};
        tick(4);
        sclk = 1'b0;
    endtask

    task automatic frame(int n, logic [31:0] bits);
        csn = 1'b0; tick(4);
        for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
        tick(4);
        csn = 1'b1;
        if (!m_clr_low) m_inp[m_sh[15:14]] = m_sh[7:0];
        model_settle();
        tick(6);
    endtask

    task automatic ldac_pulse();
        ldac_n = 1'b0; tick(6); ldac_n = 1'b1;
        if (!m_clr_low) for (int c = 0; c < 4; c++) m_dac[c] = m_inp[c];
        tick(4);
    endtask

    task automatic clr_pulse();
        clr_n = 1'b0; m_clr_low = 1'b1; model_settle();
        tick(6); clr_n = 1'b1; m_clr_low = 1'b0; tick(4);
    endtask

    task automatic expect_out(string tag);
        exp_t e;
        e.tag  = tag;
        e.dac  = {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
        e.shdn = shdn;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    // monitor
    initial begin
        forever begin
            exp_t e;
            wait (q.size() != 0);
            repeat (8) @(negedge clk);
            e = q.pop_front();
            tests++;
            if (dac_o !== e.dac || shdn_o !== e.shdn) begin
                fails++;
                $display("FAIL %s: got dac=%h shdn=%b expected dac=%h shdn=%b",
                         e.tag, dac_o, shdn_o, e.dac, e.shdn);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_inp[c] = '0; m_dac[c] = '0; end
        tick(3); rst_n = 1'b1; tick(2);
        expect_out("R1 reset state");

        frame(16, {16'h0, 2'b00, 6'h3F, 8'hA5});
        expect_out("R5 codes hold before strobe");
        frame(16, {16'h0, 2'b01, 6'h15, 8'h3C});
        frame(16, {16'h0, 2'b10, 6'h2A, 8'h7E});
        frame(16, {16'h0, 2'b11, 6'h00, 8'h81});
        ldac_pulse();
        expect_out("R2 R5 four channels loaded together");

        frame(16, {16'h0, 2'b01, 6'h3F, 8'h11});
        expect_out("R3 staging write not yet visible");
        ldac_pulse();
        expect_out("R3 only channel B changed");

        clr_pulse();
        expect_out("R7 wipe zeroes all");
        sdi = 1'b1;
        for (int i = 0; i < 5; i++) begin tick(4); sclk = 1'b1; tick(4); sclk = 1'b0; end
        frame(0, 32'h0);
        ldac_pulse();
        expect_out("R4 R7 shift register kept across wipe and idle clocks");

        ldac_n = 1'b0; m_ldac_low = 1'b1; model_settle(); tick(6);
        frame(16, {16'h0, 2'b00, 6'h01, 8'h5A});
        expect_out("R6 transparent follow A");
        frame(16, {16'h0, 2'b11, 6'h02, 8'hC3});
        expect_out("R6 transparent follow D");

        clr_n = 1'b0; m_clr_low = 1'b1; model_settle(); tick(6);
        frame(16, {16'h0, 2'b10, 6'h00, 8'h99});
        expect_out("R8 wipe beats strobe and write");
        clr_n = 1'b1; m_clr_low = 1'b0; model_settle(); tick(6);
        ldac_n = 1'b1; m_ldac_low = 1'b0; tick(6);
        frame(16, {16'h0, 2'b10, 6'h00, 8'h99});
        ldac_pulse();
        expect_out("R8 normal load after wipe release");

        frame(20, {12'h0, 4'hF, 2'b11, 6'h00, 8'h42});
        ldac_pulse();
        expect_out("R10 long frame uses last 16 bits");
        frame(8, {24'h0, 8'h77});
        ldac_pulse();
        expect_out("R10 short frame reuses old bits");

        shdn = 1'b1; tick(4);
        expect_out("R9 shutdown flag raised codes intact");
        frame(16, {16'h0, 2'b00, 6'h00, 8'hE7});
        ldac_pulse();
        expect_out("R9 writes still work in shutdown");
        shdn = 1'b0; tick(4);
        expect_out("R9 shutdown flag cleared");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule